// File: doc/BRIEF.md
# Weighted-Sum Concurrent Error Checker

This block watches the m-bit result vector of a functional logic circuit and the check vector that a separate reference block produces for it. It works out from the result vector a sum code in which every bit counts one, except a single bit whose position and weight are fixed by parameters. It then compares this value with the supplied check vector, and a difference means a fault in the circuit under watch.

A mode input turns the weighted bit into an ordinary bit of weight one, which gives a plain Berger-style count of ones. The comparison result is registered. The block drives two outputs: a per-sample mismatch flag and a sticky error flag that stays set until it is cleared.

Top module: `wsc_checker`

## Requirements
- R1: Sampled with `in_valid` high and `berger_mode` low, the expected code is the number of set data bits other than bit `WPOS`, plus the effective weight when bit `WPOS` is set. `mismatch_q` is high in the cycle after that sample exactly when `check_in`, read as an unsigned binary number, differs from the expected code.
- R2: When `berger_mode` is high, every data bit has weight one and the expected code is the count of ones in `data_in`.
- R3: The effective weight is `WEIGHT` limited to the range 2 to `DATA_W`. A `WEIGHT` above `DATA_W` acts exactly like `DATA_W`.
- R4: A cycle with `in_valid` low gives `mismatch_q` low in the next cycle and leaves `err_sticky_q` unchanged, whatever `data_in` and `check_in` carry.
- R5: `err_sticky_q` is set in the cycle in which `mismatch_q` rises, and it stays set until a cycle with `clr_sticky` high. If a new mismatch is sampled in the same cycle as a clear, the set wins.
- R6: A synchronous active-high `rst` clears both `mismatch_q` and `err_sticky_q` on the next clock edge.
- R7: Take a correct codeword and change data bits in one direction only, either all 0-to-1 or all 1-to-0, leaving the check vector as it was. Such a unidirectional error always produces a mismatch.
- R8: `check_in` is ceil(log2(DATA_W + effective weight)) bits wide. The all-ones data vector with its full code of `DATA_W`-1 plus the effective weight is accepted without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies a sample of data and check vectors |
| berger_mode | input | 1 | High: all weights equal one |
| clr_sticky | input | 1 | Clears the sticky error flag |
| data_in | input | DATA_W | Result vector of the watched circuit |
| check_in | input | CHK_W | Check vector from the reference block |
| mismatch_q | output | 1 | Registered per-sample mismatch |
| err_sticky_q | output | 1 | Sticky error flag |

## Verification
The bench builds two instances. The first uses an 8-bit data vector with the weight 5 on bit 3, a weight strictly between 2 and the width. There, weighted and Berger sums differ, and random non-unidirectional flips yield both detected and undetected swaps. The second sets the weight to 20 on bit 0, so only the clamp to 8 makes its correct codewords pass, and the full code 15 fills the 4-bit check vector exactly.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    // Weight limited to the useful range [2, m]
    function automatic int eff_weight(input int w, input int m);
        if (w < 2) return 2;
        if (w > m) return m;
        return w;
    endfunction

    // Bits needed for the largest sum (m-1+weight)
    function automatic int chk_width(input int w, input int m);
        return $clog2(m + eff_weight(w, m));
    endfunction

    typedef struct packed {
        logic mismatch;
        logic sticky;
    } wsc_flags_t;

endpackage

// File: rtl/wsc_sum_unit.sv
module wsc_sum_unit #(
    parameter int DATA_W = 8,
    parameter int WPOS   = 3,
    parameter int W_EFF  = 5,
    parameter int CHK_W  = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic              berger,
    output logic [CHK_W-1:0]  sum
);
    logic [CHK_W-1:0] term [DATA_W];

    for (genvar i = 0; i < DATA_W; i++) begin : g_term
        localparam int BIT_W = (i == WPOS) ? W_EFF : 1;
        if (BIT_W == 1) begin : g_unit
            assign term[i] = CHK_W'(data[i]);
        end else begin : g_weighted
            always_comb begin
                if (!data[i])    term[i] = '0;
                else if (berger) term[i] = CHK_W'(1);
                else             term[i] = CHK_W'(BIT_W);
            end
        end
    end

    always_comb begin
        logic [CHK_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < DATA_W; i++) acc = acc + term[i];
        sum = acc;
    end
endmodule

// File: rtl/wsc_compare.sv
module wsc_compare #(
    parameter int CHK_W = 4
) (
    input  logic [CHK_W-1:0] calc,
    input  logic [CHK_W-1:0] ref_chk,
    output logic             differ
);
    assign differ = |(calc ^ ref_chk);
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
    parameter int DATA_W = 8,
    parameter int WPOS   = 3,
    parameter int WEIGHT = 5,
    localparam int W_EFF = wsc_pkg::eff_weight(WEIGHT, DATA_W),
    localparam int CHK_W = wsc_pkg::chk_width(WEIGHT, DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              berger_mode,
    input  logic              clr_sticky,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  check_in,
    output logic              mismatch_q,
    output logic              err_sticky_q
);
    import wsc_pkg::*;

    logic [CHK_W-1:0] calc_sum;
    logic             differ;
    wsc_flags_t       flags_d, flags_q;

    wsc_sum_unit #(
        .DATA_W (DATA_W),
        .WPOS   (WPOS),
        .W_EFF  (W_EFF),
        .CHK_W  (CHK_W)
    ) u_sum (
        .data   (data_in),
        .berger (berger_mode),
        .sum    (calc_sum)
    );

    wsc_compare #(.CHK_W(CHK_W)) u_cmp (
        .calc    (calc_sum),
        .ref_chk (check_in),
        .differ  (differ)
    );

    always_comb begin
        logic hit;
        hit              = in_valid & differ;
        flags_d          = flags_q;
        flags_d.mismatch = hit;
        flags_d.sticky   = (flags_q.sticky & ~clr_sticky) | hit;
        if (rst) flags_d = '0;
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign mismatch_q   = flags_q.mismatch;
    assign err_sticky_q = flags_q.sticky;
endmodule

// File: rtl/wsc_checker_sva.sv
module wsc_checker_sva (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic clr_sticky,
    input logic mismatch_q,
    input logic err_sticky_q
);
    // R4
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !mismatch_q);

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_sticky_q && !clr_sticky) |=> err_sticky_q);

    // R5
    sticky_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mismatch_q |-> err_sticky_q);

    // R5
    sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_sticky && !in_valid) |=> !err_sticky_q);

    // R6
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mismatch_q && !err_sticky_q));
endmodule

bind wsc_checker wsc_checker_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .clr_sticky   (clr_sticky),
    .mismatch_q   (mismatch_q),
    .err_sticky_q (err_sticky_q)
);

// File: tb/wsc_checker_tb.sv
`timescale 1ns/1ps
module wsc_checker_tb;
    localparam int DW   = 8;
    localparam int POSA = 3;
    localparam int WA   = 5;
    localparam int POSB = 0;
    localparam int WB   = 20;
    localparam int WBE  = (WB > DW) ? DW : WB;   // R3 clamp, from the requirement
    localparam int CKA  = $clog2(DW + WA);
    localparam int CKB  = $clog2(DW + WBE);

    logic clk = 0;
    always #2.5 clk = ~clk;

    logic          rst = 1, vld = 0, bm = 0, clr = 0;
    logic [DW-1:0] d = '0;
    logic [CKA-1:0] cka = '0;
    logic [CKB-1:0] ckb = '0;
    logic mis_a, st_a, mis_b, st_b;

    int checks = 0, failures = 0;
    logic em_a = 0, es_a = 0, em_b = 0, es_b = 0;

    wsc_checker #(.DATA_W(DW), .WPOS(POSA), .WEIGHT(WA)) u_dut (
        .clk(clk), .rst(rst), .in_valid(vld), .berger_mode(bm),
        .clr_sticky(clr), .data_in(d), .check_in(cka),
        .mismatch_q(mis_a), .err_sticky_q(st_a));

    wsc_checker #(.DATA_W(DW), .WPOS(POSB), .WEIGHT(WB)) u_dut_clamp (
        .clk(clk), .rst(rst), .in_valid(vld), .berger_mode(bm),
        .clr_sticky(clr), .data_in(d), .check_in(ckb),
        .mismatch_q(mis_b), .err_sticky_q(st_b));

    function automatic int ref_sum(input logic [DW-1:0] v, input int pos,
                                   input int w, input logic berger);
        int s = 0;
        for (int i = 0; i < DW; i++)
            if (v[i]) s += (berger || i != pos) ? 1 : w;
        return s;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic r, input logic v,
                       input logic b, input logic c, input logic [DW-1:0] dv,
                       input int ca, input int cb);
        logic ha, hb;
        @(negedge clk);
        rst = r; vld = v; bm = b; clr = c; d = dv;
        cka = CKA'(ca); ckb = CKB'(cb);
        ha = v && (ref_sum(dv, POSA, WA, b) != ca);
        hb = v && (ref_sum(dv, POSB, WBE, b) != cb);
        em_a = r ? 1'b0 : ha;  es_a = r ? 1'b0 : ((es_a & ~c) | ha);
        em_b = r ? 1'b0 : hb;  es_b = r ? 1'b0 : ((es_b & ~c) | hb);
        @(posedge clk); #1;
        check({tag, " mismatch A"}, mis_a, em_a);
        check({tag, " sticky A"},   st_a,  es_a);
        check({tag, " mismatch B"}, mis_b, em_b);
        check({tag, " sticky B"},   st_b,  es_b);
    endtask

    task automatic clear_all();
        cyc("R5 clear", 0, 0, 0, 1, '0, 0, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] dv, m, e;
        // R6 reset state
        cyc("R6 reset", 1, 1, 0, 0, 8'hFF, 0, 0);
        cyc("R6 reset", 1, 0, 0, 0, '0, 0, 0);
        check("R6 reset mismatch", mis_a, 1'b0);

        // R1 correct codewords pass
        for (int n = 0; n < 20; n++) begin
            dv = DW'($urandom);
            cyc("R1 codeword", 0, 1, 0, 0, dv, ref_sum(dv, POSA, WA, 0),
                ref_sum(dv, POSB, WBE, 0));
        end
        // R8 all ones, full code without wrap
        cyc("R8 all-ones", 0, 1, 0, 0, '1, DW - 1 + WA, DW - 1 + WBE);
        check("R8 all-ones no flag", mis_b, 1'b0);

        // R3 clamp: weighted bit alone must count as DW
        cyc("R3 clamp", 0, 1, 0, 0, DW'(1), 1, DW);
        check("R3 clamp accepts weight m", mis_b, 1'b0);

        // R7 unidirectional errors, up and down
        for (int n = 0; n < 30; n++) begin
            dv = DW'($urandom);
            if (dv == '1) dv = DW'(8'h5A);
            if (dv == '0) dv = DW'(8'h5A);
            if (n % 2 == 0) begin
                m = DW'($urandom) & ~dv;
                if (m == '0) m = (~dv) & -(~dv);
                e = dv | m;
            end else begin
                m = DW'($urandom) & dv;
                if (m == '0) m = dv & -dv;
                e = dv & ~m;
            end
            cyc("R7 unidirectional", 0, 1, 0, 0, e,
                ref_sum(dv, POSA, WA, 0), ref_sum(dv, POSB, WBE, 0));
            check("R7 unidirectional detected A", mis_a, 1'b1);
            check("R7 unidirectional detected B", mis_b, 1'b1);
        end
        clear_all();

        // R1 random non-unidirectional errors
        for (int n = 0; n < 60; n++) begin
            dv = DW'($urandom);
            e  = dv ^ DW'($urandom);
            cyc("R1 random flip", 0, 1, 0, n % 7 == 0, e,
                ref_sum(dv, POSA, WA, 0), ref_sum(dv, POSB, WBE, 0));
        end
        clear_all();
        // R1 undetected swap: bit3 (w5) on vs bits 0,1,2,4,5 on => same sum
        cyc("R1 swap equal sum", 0, 1, 0, 0, 8'b0011_0111, 5, 5);
        check("R1 equal-sum swap passes A", mis_a, 1'b0);

        // R2 Berger mode
        for (int n = 0; n < 15; n++) begin
            dv = DW'($urandom);
            cyc("R2 berger", 0, 1, 1, 0, dv, $countones(dv), $countones(dv));
        end
        cyc("R2 berger rejects weighted code", 0, 1, 1, 0, 8'b0000_1000, WA, 1);
        check("R2 weighted code flagged in berger", mis_a, 1'b1);
        clear_all();

        // R4 invalid sample ignored
        cyc("R4 invalid", 0, 0, 0, 0, 8'hFF, 0, 0);
        check("R4 invalid no mismatch", mis_a, 1'b0);
        check("R4 invalid sticky kept clear", st_a, 1'b0);

        // R5 sticky hold, then set wins over clear
        cyc("R5 set", 0, 1, 0, 0, 8'h01, 0, 0);
        cyc("R5 hold", 0, 1, 0, 0, 8'h01, 1, DW);
        check("R5 sticky held", st_a, 1'b1);
        cyc("R4 invalid keeps sticky", 0, 0, 0, 0, 8'hFF, 0, 0);
        check("R4 sticky unchanged", st_a, 1'b1);
        cyc("R5 set over clear", 0, 1, 0, 1, 8'h01, 0, 0);
        check("R5 set wins", st_a, 1'b1);
        clear_all();
        check("R5 cleared", st_a, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule